// File: doc/BRIEF.md
# LCD segment refresh scanner

The scanner is the display half of a 64-column segment driver. It runs on a fast system clock and samples the slow panel timing signals through synchronizers: a frame pulse, a line clock and the AC polarity signal. A 6-bit line counter is loaded with a scroll offset (the start line) whenever the frame signal is high and otherwise steps by one on every falling line-clock edge, wrapping from 63 to 0. After each step the scanner sweeps all 64 column addresses of a byte-organised display RAM and extracts from each byte the single bit that belongs to the current line. The result is a 64-bit row held in a shadow register.

On the next rising line-clock edge the shadow row is copied into the display latch, or a blank row is loaded instead if the display is switched off. Each column of the latch is routed to an output slot in forward or mirrored order, as a strap input selects. The column bit and the polarity signal are then encoded into one of four drive-level codes, which select the analog switches of that segment.

Top module: `seg_refresh_scanner`

## Requirements
- R1: After reset every segment code is 3 (the unlit level for polarity 0), the line counter is 0, the display latch is blank and no RAM read is active.
- R2: While the synchronized frame signal is high the line counter is loaded with `start_line_i` on every cycle. A falling line-clock edge seen while the frame signal is high therefore fetches the start line.
- R3: On a falling line-clock edge with the frame signal low the line counter increments by one and wraps from 63 to 0.
- R4: The fetch for line L reads the RAM at address {L[5:3], column} for columns 0 to 63, with the column in address bits [5:0] and the page in bits [8:6], and takes bit L[2:0] of each returned byte. The RAM returns data one clock after the address is presented with `ram_rd_o` high.
- R5: The display latch changes only on a rising line-clock edge. It then takes the row fetched after the previous falling edge, and before any fetch it is blank.
- R6: If `disp_on_i` is low at a rising line-clock edge the latch is loaded blank, so every segment shows an unlit code. The RAM is not touched, so the next capture with the display on shows the stored data again. `disp_on_i` has no effect between captures.
- R7: With `col_dir_i` high, output slot j (bits [2j+1:2j]) shows column j. With it low, slot j shows column 63-j.
- R8: Segment code = {~D, ~M}: lit with M=1 gives 0 (V1), lit with M=0 gives 1 (V2), unlit with M=1 gives 2 (V3), unlit with M=0 gives 3 (V4).
- R9: A change of `start_line_i` has no effect on the line sequence until the frame signal is next high.
- R10: A change of `pol_i` shows on all segment codes within 3 system clocks, without any line-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the line clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_i | input | 1 | Frame signal; high loads the scroll offset |
| cl_i | input | 1 | Line clock; the fall advances and fetches, the rise latches |
| pol_i | input | 1 | AC polarity signal M |
| col_dir_i | input | 1 | Column order strap: 1 forward, 0 mirrored |
| disp_on_i | input | 1 | Display on flag, sampled at each latch capture |
| start_line_i | input | 6 | Display start line (scroll offset) |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_addr_o | output | 9 | RAM address {page, column} |
| ram_rdata_i | input | 8 | RAM byte, valid one clock after the strobe |
| seg_lvl_o | output | 128 | 64 two-bit drive-level codes, slot j in bits [2j+1:2j] |

## Verification
The bench targets four corner cases.
- The line wrap from 63 to 0. A counter that saturates or skips there would show the wrong row after line 63.
- A page boundary (line 7 to 8). A wrong split of the line into page and bit would repeat or scramble rows there.
- The frame signal held high over several lines. The row must then stay frozen at the start line.
- A start-line change without a frame pulse. This must leave the sequence alone, and a design that reloads too early would jump.

Blanking, mirroring and polarity are all checked against a model that is computed from the RAM pattern. These checks expose a latch that reacts to the on flag or to polarity between captures. They also expose a blank that damages later rows, and a reversed or offset column map.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      LVL_V1 = 2'd0,
      LVL_V2 = 2'd1,
      LVL_V3 = 2'd2,
      LVL_V4 = 2'd3
   } lvl_e;

   // drive level from dot state and polarity
   function automatic lvl_e lvl_code(input logic dot, input logic pol);
      return lvl_e'({~dot, ~pol});
   endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int W   = 1,
   parameter int STG = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   if (STG < 2) begin : g_bad_stg
      $error("edge_sync needs at least two stages");
   end

   logic [STG-1:0][W-1:0] stg_q;
   logic [W-1:0]          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= async_i;
         for (int i = 1; i < STG; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[STG-1];
      end
   end

   assign lvl_o  = stg_q[STG-1];
   assign rise_o = stg_q[STG-1] & ~prev_q;
   assign fall_o = ~stg_q[STG-1] & prev_q;
endmodule

// File: rtl/line_counter.sv
module line_counter #(
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset_i,
   input  logic              step_i,
   input  logic [LINE_W-1:0] start_i,
   output logic [LINE_W-1:0] line_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        line_o <= '0;
      else if (preset_i) line_o <= start_i;
      else if (step_i)   line_o <= line_o + 1'b1;
   end
endmodule

// File: rtl/line_fetch.sv
module line_fetch #(
   parameter int NCOL   = 64,
   parameter int LINE_W = 6,
   parameter int BYTE_W = 8,
   localparam int COL_W  = $clog2(NCOL),
   localparam int BIT_W  = $clog2(BYTE_W),
   localparam int PAGE_W = LINE_W - BIT_W,
   localparam int ADDR_W = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [LINE_W-1:0] line_i,
   output logic              ram_rd_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   input  logic [BYTE_W-1:0] ram_rdata_i,
   output logic [NCOL-1:0]   row_o
);
   logic              busy_q, vld_q;
   logic [COL_W-1:0]  col_q, col_d;
   logic [LINE_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         col_q  <= '0;
         sel_q  <= '0;
      end else if (go_i) begin
         busy_q <= 1'b1;
         col_q  <= '0;
         sel_q  <= line_i;
      end else if (busy_q) begin
         if (col_q == COL_W'(NCOL - 1)) busy_q <= 1'b0;
         col_q <= col_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         col_d <= '0;
         row_o <= '0;
      end else begin
         vld_q <= busy_q;
         col_d <= col_q;
         if (vld_q) row_o[col_d] <= ram_rdata_i[sel_q[BIT_W-1:0]];
      end
   end

   assign ram_rd_o   = busy_q;
   assign ram_addr_o = {sel_q[LINE_W-1:BIT_W], col_q};
endmodule

// File: rtl/seg_refresh_scanner.sv
module seg_refresh_scanner #(
   parameter int NCOL     = 64,
   parameter int LINE_W   = 6,
   parameter int BYTE_W   = 8,
   parameter int SYNC_STG = 2,
   localparam int COL_W  = $clog2(NCOL),
   localparam int BIT_W  = $clog2(BYTE_W),
   localparam int ADDR_W = LINE_W - BIT_W + COL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frm_i,
   input  logic                cl_i,
   input  logic                pol_i,
   input  logic                col_dir_i,
   input  logic                disp_on_i,
   input  logic [LINE_W-1:0]   start_line_i,
   output logic                ram_rd_o,
   output logic [ADDR_W-1:0]   ram_addr_o,
   input  logic [BYTE_W-1:0]   ram_rdata_i,
   output logic [2*NCOL-1:0]   seg_lvl_o
);
   import scan_pkg::*;

   if (NCOL != (1 << COL_W)) begin : g_bad_ncol
      $error("NCOL must be a power of two");
   end
   if (BYTE_W != (1 << BIT_W) || LINE_W <= BIT_W) begin : g_bad_byte
      $error("BYTE_W must be a power of two below 2**LINE_W");
   end

   logic [2:0] s_lvl, s_rise, s_fall;
   logic       frm_s, pol_s, cl_rise, cl_fall, fetch_go;
   logic [LINE_W-1:0] line_q;
   logic [NCOL-1:0]   shadow_row, disp_lat;

   edge_sync #(.W(3), .STG(SYNC_STG)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i({pol_i, cl_i, frm_i}),
      .lvl_o  (s_lvl),
      .rise_o (s_rise),
      .fall_o (s_fall)
   );

   assign frm_s   = s_lvl[0];
   assign pol_s   = s_lvl[2];
   assign cl_rise = s_rise[1];
   assign cl_fall = s_fall[1];

   line_counter #(.LINE_W(LINE_W)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .preset_i(frm_s),
      .step_i  (cl_fall),
      .start_i (start_line_i),
      .line_o  (line_q)
   );

   // fetch starts once the counter holds the new line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fetch_go <= 1'b0;
      else        fetch_go <= cl_fall;
   end

   line_fetch #(.NCOL(NCOL), .LINE_W(LINE_W), .BYTE_W(BYTE_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (fetch_go),
      .line_i     (line_q),
      .ram_rd_o   (ram_rd_o),
      .ram_addr_o (ram_addr_o),
      .ram_rdata_i(ram_rdata_i),
      .row_o      (shadow_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       disp_lat <= '0;
      else if (cl_rise) disp_lat <= disp_on_i ? shadow_row : '0;
   end

   for (genvar j = 0; j < NCOL; j++) begin : g_seg
      logic dot;
      assign dot = col_dir_i ? disp_lat[j] : disp_lat[NCOL-1-j];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seg_lvl_o[2*j +: 2] <= LVL_V4;
         else        seg_lvl_o[2*j +: 2] <= lvl_code(dot, pol_s);
      end
   end
endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
   parameter int NCOL   = 64,
   parameter int LINE_W = 6,
   parameter int ADDR_W = 9,
   parameter int COL_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cl_rise,
   input logic              cl_fall,
   input logic              frm_s,
   input logic              disp_on_i,
   input logic [LINE_W-1:0] start_line_i,
   input logic [LINE_W-1:0] line_q,
   input logic [NCOL-1:0]   disp_lat,
   input logic              ram_rd_o,
   input logic [ADDR_W-1:0] ram_addr_o
);
   p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_s |=> line_q == $past(start_line_i));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_fall && !frm_s && line_q == {LINE_W{1'b1}}) |=> line_q == '0);

   p_page_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd_o && $past(ram_rd_o)) |-> $stable(ram_addr_o[ADDR_W-1:COL_W]));

   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cl_rise |=> $stable(disp_lat));

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_rise && !disp_on_i) |=> disp_lat == '0);
endmodule

bind seg_refresh_scanner scan_chk #(
   .NCOL(NCOL), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .COL_W(COL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cl_rise     (cl_rise),
   .cl_fall     (cl_fall),
   .frm_s       (frm_s),
   .disp_on_i   (disp_on_i),
   .start_line_i(start_line_i),
   .line_q      (line_q),
   .disp_lat    (disp_lat),
   .ram_rd_o    (ram_rd_o),
   .ram_addr_o  (ram_addr_o)
);

// File: tb/seg_refresh_scanner_test.sv
module seg_refresh_scanner_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 100;
   localparam int NROW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frm = 1'b0, cl = 1'b0, pol = 1'b0, dir = 1'b1, on = 1'b1;
   logic [5:0] start = '0;
   logic ram_rd;
   logic [8:0] ram_addr;
   logic [7:0] ram_q = '0;
   logic [127:0] seg;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   int z = 0, fetched = 0, shown = 0;
   bit fetched_vld = 0, shown_on = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_refresh_scanner uut (
      .clk(clk), .rst_n(rst_n), .frm_i(frm), .cl_i(cl), .pol_i(pol),
      .col_dir_i(dir), .disp_on_i(on), .start_line_i(start),
      .ram_rd_o(ram_rd), .ram_addr_o(ram_addr), .ram_rdata_i(ram_q),
      .seg_lvl_o(seg)
   );

   function automatic logic [7:0] byte_of(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   always @(posedge clk) if (ram_rd) ram_q <= byte_of(int'(ram_addr));

   // R4 R7 R8: expected codes from the RAM pattern
   function automatic logic [127:0] exp_seg(input int line, input bit dsp,
                                            input bit d_fwd, input bit m);
      logic [127:0] r;
      for (int j = 0; j < 64; j++) begin
         int col;
         logic [7:0] b;
         logic d;
         col = d_fwd ? j : 63 - j;
         b = byte_of(((line >> 3) << 6) | col);
         d = dsp & b[line & 7];
         r[2*j +: 2] = {~d, ~m};
      end
      return r;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cl_rise_step();
      cl = 1'b1;
      shown = fetched;
      shown_on = on & fetched_vld;
      wait_clk(HALF);
   endtask

   task automatic cl_fall_step();
      cl = 1'b0;
      z = frm ? int'(start) : (z + 1) % 64;
      fetched = z;
      fetched_vld = 1;
      wait_clk(HALF);
   endtask

   // {frm, on, dir, pol, start}
   localparam logic [9:0] VEC [NROW] = '{
      {1'b1,1'b1,1'b1,1'b1,6'd5},   // R2 preset
      {1'b0,1'b1,1'b1,1'b0,6'd5},
      {1'b0,1'b1,1'b0,1'b1,6'd5},   // R7 mirrored
      {1'b0,1'b1,1'b1,1'b1,6'd5},   // R4 page step 7 -> 8
      {1'b1,1'b1,1'b1,1'b0,6'd62},
      {1'b0,1'b1,1'b1,1'b1,6'd62},
      {1'b0,1'b1,1'b0,1'b0,6'd62},  // R3 wrap 63 -> 0
      {1'b0,1'b0,1'b1,1'b1,6'd62},  // R6 blank
      {1'b0,1'b1,1'b1,1'b1,6'd62},  // R6 data back
      {1'b0,1'b1,1'b1,1'b0,6'd20},  // R9 no early reload
      {1'b1,1'b1,1'b0,1'b1,6'd20},
      {1'b0,1'b1,1'b1,1'b0,6'd20},
      {1'b1,1'b1,1'b1,1'b1,6'd40},  // R2 held high
      {1'b1,1'b1,1'b1,1'b0,6'd40},
      {1'b0,1'b1,1'b1,1'b1,6'd40},
      {1'b0,1'b1,1'b0,1'b1,6'd40}
   };

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      check("R1 reset codes", seg, {128{1'b1}});
      check("R1 no read", {127'd0, ram_rd}, 128'd0);

      // R5: first capture before any fetch is blank
      cl_rise_step();
      check("R5 blank before fetch", seg, exp_seg(0, 0, dir, pol));
      cl_fall_step();

      for (int i = 0; i < NROW; i++) begin
         {frm, on, dir, pol, start} = VEC[i];
         wait_clk(5);
         cl_rise_step();
         check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 row %0d line %0d", i, shown),
               seg, exp_seg(shown, shown_on, dir, pol));
         cl_fall_step();
      end

      // R10: polarity change with no line clock
      pol = ~pol;
      wait_clk(4);
      check("R10 polarity", seg, exp_seg(shown, shown_on, dir, pol));

      // R6: on flag ignored between captures
      on = 1'b0;
      wait_clk(20);
      check("R6 off between captures", seg, exp_seg(shown, shown_on, dir, pol));
      cl_rise_step();
      check("R6 off at capture", seg, exp_seg(shown, 0, dir, pol));
      cl_fall_step();
      on = 1'b1;
      cl_rise_step();
      check("R6 on again", seg, exp_seg(shown, 1, dir, pol));

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule